// File: doc/BRIEF.md
# Interval Reload Timer

A 16-bit down-counting interval timer that sits on a simple peripheral register bus. Software programs a reload value N and a prescaler selection, then drives the timer only through write-one command bits: go, halt and clear. While running, the counter steps down once per prescaled tick. When a tick arrives at a count of zero, the counter reloads N, a sticky pending flag is set and the interrupt line rises. The pending flag and the run state can be read back in the control register.

One interval lasts (N+1) prescaled ticks, so the time between interrupts is (N+1) * 2^s clock cycles for a divide selection s. Commands written in the same access follow a fixed priority. Halt is strongest and also drops any pending interrupt. Clear comes next, and go is weakest. The interrupt output is the pending flag itself, so it stays high until software clears it or halts the timer.

Top module: `intv_timer`

## Requirements
- R1: After reset the timer is stopped, irq is 0, and both registers read 0.
- R2: Register map: address 0 holds the reload value (read/write, bits 15:0). Address 1 is the control register: bit 0 is go on write and reads back the run state, bit 1 is halt, bit 2 is clear, bit 3 is the pending flag, and bits 6:4 are the divide selection (read/write). Bits 1 and 2 always read 0.
- R3: Writing 1 to go while the timer is stopped starts it with the count loaded to N and the prescaler restarted. The first irq rise comes exactly (N+1)*2^s cycles after the clock edge that took the write.
- R4: Writing 1 to go while the timer is running has no effect on the count or on the interval.
- R5: Writing 1 to halt stops the timer and clears the pending flag and irq in the same cycle. Halt wins over go written in the same access.
- R6: Writing 1 to clear drops the pending flag and irq. If an underflow happens on the same edge, the flag stays set. Clear written together with go on a running timer clears the flag and leaves the timer running.
- R7: On each underflow the counter reloads the value currently held in the reload register and keeps counting, so interrupts repeat every (N+1)*2^s cycles. A new reload value takes effect at the next reload.
- R8: The pending flag cannot be written. irq equals the flag and stays high until a clear or a halt.
- R9: Divide selection values 0 to 6 give a tick every 2^s cycles. Value 7 behaves as 6 (divide by 64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 1 | Register select: 0 reload, 1 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, equal to the pending flag |

## Verification
The bench measures the interval as the cycle distance from the go edge to the irq rise, and between successive rises. An off-by-one in the prescaler or in the counter's zero handling shows up as a wrong period, and so does a missing clamp of selection 7. It aims a clear write at the same edge as an underflow with N=0: a design that lets clear win would drop irq there. It writes go while the timer is running and writes go together with halt. A design that reloads on a redundant go would stretch the interval, and one that honours go over halt would keep running. It also rewrites the reload value in the middle of an interval, where a design that loads the new value at once would give the wrong next period.

// File: rtl/intv_pkg.sv
package intv_pkg;
  typedef enum logic [0:0] {
    REG_RELOAD = 1'b0,
    REG_CTRL   = 1'b1
  } intv_reg_e;

  // control register bit positions
  localparam int unsigned BIT_GO   = 0;
  localparam int unsigned BIT_HALT = 1;
  localparam int unsigned BIT_CLR  = 2;
  localparam int unsigned BIT_PEND = 3;
  localparam int unsigned DIV_LSB  = 4;

  typedef struct packed {
    logic go;
    logic halt;
    logic clr;
  } intv_cmd_t;
endpackage

// File: rtl/intv_prescaler.sv
module intv_prescaler #(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_SHIFT);

  logic [SEL_W-1:0] shift_eff;
  logic [PRE_W-1:0] mask;
  logic [PRE_W-1:0] pre_q, pre_d;

  assign shift_eff = (div_sel > MAX_SEL) ? MAX_SEL : div_sel;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (shift_eff > SEL_W'(i));
  end

  always_comb begin
    pre_d = pre_q;
    if (restart)  pre_d = '0;
    else if (run) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run && !restart && ((pre_q & mask) == mask);
endmodule

// File: rtl/intv_counter.sv
module intv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             uf
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = run && tick;
  assign uf   = step && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = reload_val;
    else if (uf)   cnt_d = reload_val;
    else if (step) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/intv_regs.sv
module intv_regs
  import intv_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              uf,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload_val,
  output logic [SEL_W-1:0]  div_sel,
  output logic              run,
  output logic              start_evt,
  output logic              flag
);
  logic [CNT_W-1:0] reload_q, reload_d;
  logic [SEL_W-1:0] div_q, div_d;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             reload_we, ctrl_we;
  intv_cmd_t        cmd;

  assign reload_we = bus_wr && (bus_addr == REG_RELOAD);
  assign ctrl_we   = bus_wr && (bus_addr == REG_CTRL);

  assign cmd.go   = ctrl_we && bus_wdata[BIT_GO];
  assign cmd.halt = ctrl_we && bus_wdata[BIT_HALT];
  assign cmd.clr  = ctrl_we && bus_wdata[BIT_CLR];

  // halt > clear > go; go only acts on a stopped timer
  assign start_evt = cmd.go && !cmd.halt && !run_q;

  always_comb begin
    reload_d = reload_q;
    div_d    = div_q;
    run_d    = run_q;
    flag_d   = flag_q;
    if (reload_we) reload_d = bus_wdata[CNT_W-1:0];
    if (ctrl_we)   div_d    = bus_wdata[DIV_LSB +: SEL_W];
    if (cmd.halt)       run_d = 1'b0;
    else if (start_evt) run_d = 1'b1;
    if (cmd.halt)      flag_d = 1'b0;
    else if (uf)       flag_d = 1'b1;
    else if (cmd.clr)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      div_q    <= '0;
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      reload_q <= reload_d;
      div_q    <= div_d;
      run_q    <= run_d;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (bus_addr == REG_RELOAD) begin
      rdata[CNT_W-1:0] = reload_q;
    end else begin
      rdata[BIT_GO]              = run_q;
      rdata[BIT_PEND]            = flag_q;
      rdata[DIV_LSB +: SEL_W]    = div_q;
    end
  end

  assign reload_val = reload_q;
  assign div_sel    = div_q;
  assign run        = run_q;
  assign flag       = flag_q;
endmodule

// File: rtl/intv_timer.sv
module intv_timer #(
  parameter int CNT_W     = 16,
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 6,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] reload_val, cnt_q;
  logic [SEL_W-1:0] div_sel;
  logic             run_q, start_evt, tick, uf, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  intv_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .uf         (uf),
    .rdata      (bus_rdata),
    .reload_val (reload_val),
    .div_sel    (div_sel),
    .run        (run_q),
    .start_evt  (start_evt),
    .flag       (flag)
  );

  intv_prescaler #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (run_q),
    .restart (start_evt),
    .div_sel (div_sel),
    .tick    (tick)
  );

  intv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (start_evt),
    .run        (run_q),
    .tick       (tick),
    .reload_val (reload_val),
    .cnt        (cnt_q),
    .uf         (uf)
  );

  assign irq = flag;
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             go_bit,
  input logic             halt_bit,
  input logic             clr_bit,
  input logic             irq,
  input logic             run,
  input logic [CNT_W-1:0] cnt
);
  p_go_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && go_bit && !halt_bit |=> run);

  p_go_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && ctrl_wr && go_bit && !halt_bit && (cnt != '0)
    |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - 1'b1));

  p_halt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && halt_bit |=> !run && !irq);

  p_clr_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && clr_bit && !halt_bit && (cnt != '0) |=> !irq);

  p_rise_on_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run) && ($past(cnt) == '0));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(ctrl_wr && (halt_bit || clr_bit)) |=> irq);
endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .ctrl_wr  (bus_wr && bus_addr),
  .go_bit   (bus_wdata[intv_pkg::BIT_GO]),
  .halt_bit (bus_wdata[intv_pkg::BIT_HALT]),
  .clr_bit  (bus_wdata[intv_pkg::BIT_CLR]),
  .irq      (irq),
  .run      (run_q),
  .cnt      (cnt_q)
);

// File: tb/test_intv_timer.sv
module test_intv_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  intv_timer i_intv_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // control word: bit0 go, bit1 halt, bit2 clear, bit3 pending, bits 6:4 divide
  function automatic logic [15:0] cw(bit go, bit halt, bit clr, bit pend, int dv);
    logic [15:0] w = '0;
    w[0] = go; w[1] = halt; w[2] = clr; w[3] = pend; w[6:4] = 3'(dv);
    return w;
  endfunction

  function automatic int exp_period(int n, int s);
    return (n + 1) << ((s > 6) ? 6 : s);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(bit a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(output int t);
    int k = 0;
    while (!irq && k < 5000) begin
      @(negedge clk);
      k++;
    end
    t = cyc;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int t0, t1, t2, t3;
    void'($urandom(32'd24681));

    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    rd(1'b1, d); chk("R1 ctrl", int'(d), 0);
    rd(1'b0, d); chk("R1 reload", int'(d), 0);

    // R2 register map
    wr(1'b0, 16'hA5C3);
    rd(1'b0, d); chk("R2 reload readback", int'(d), 'hA5C3);
    wr(1'b1, cw(0, 0, 0, 0, 7));
    rd(1'b1, d); chk("R2 ctrl divide field", int'(d), 'h70);

    // R8 pending bit not writable
    wr(1'b1, cw(0, 0, 0, 1, 0));
    chk("R8 irq after pend write", int'(irq), 0);
    rd(1'b1, d); chk("R8 pend readback", int'(d[3]), 0);

    // R3 start, N=3, div 2 -> 8 cycles
    wr(1'b0, 16'd3);
    wr(1'b1, cw(1, 0, 0, 0, 1));
    t0 = cyc;
    rd(1'b1, d); chk("R3 run bit", int'(d[0]), 1);
    chk("R2 halt/clear bits read 0", int'(d[2:1]), 0);
    wait_irq(t1);
    chk("R3 first interval", t1 - t0, 8);
    idle(3);
    chk("R8 irq held", int'(irq), 1);

    // R6 clear, R7 periodic
    wr(1'b1, cw(0, 0, 1, 0, 1));
    chk("R6 clear drops irq", int'(irq), 0);
    wait_irq(t2);
    chk("R7 period repeat", t2 - t1, 8);

    // R4 go while running
    wr(1'b1, cw(0, 0, 1, 0, 1));
    idle(2);
    wr(1'b1, cw(1, 0, 0, 0, 1));
    wait_irq(t3);
    chk("R4 redundant go keeps interval", t3 - t2, 8);

    // R5 halt
    wr(1'b1, cw(0, 1, 0, 0, 1));
    chk("R5 halt clears irq", int'(irq), 0);
    idle(20);
    rd(1'b1, d); chk("R5 stopped", int'(d[0]), 0);
    chk("R5 no irq while stopped", int'(irq), 0);

    // R5 halt beats go
    wr(1'b1, cw(1, 1, 0, 0, 0));
    rd(1'b1, d); chk("R5 halt+go run", int'(d[0]), 0);
    idle(10);
    chk("R5 halt+go irq", int'(irq), 0);

    // R6 clear on the same edge as an underflow (N=0, div 1)
    wr(1'b0, 16'd0);
    wr(1'b1, cw(1, 0, 0, 0, 0));
    t0 = cyc;
    wait_irq(t1);
    chk("R3 N=0 interval", t1 - t0, 1);
    wr(1'b1, cw(0, 0, 1, 0, 0));
    chk("R6 underflow beats clear", int'(irq), 1);
    wr(1'b1, cw(0, 1, 0, 0, 0));

    // R6 clear with go on a running timer
    wr(1'b0, 16'd4);
    wr(1'b1, cw(1, 0, 0, 0, 0));
    wait_irq(t1);
    wr(1'b1, cw(1, 0, 1, 0, 0));
    chk("R6 clear+go irq", int'(irq), 0);
    rd(1'b1, d); chk("R6 clear+go still running", int'(d[0]), 1);
    wait_irq(t2);
    chk("R6 clear+go interval", t2 - t1, 5);
    wr(1'b1, cw(0, 1, 0, 0, 0));

    // R7 new reload value used at next reload
    wr(1'b0, 16'd2);
    wr(1'b1, cw(1, 0, 0, 0, 0));
    wait_irq(t1);
    wr(1'b0, 16'd9);
    wr(1'b1, cw(0, 0, 1, 0, 0));
    wait_irq(t2);
    chk("R7 interval after rewrite", t2 - t1, 3);
    wr(1'b1, cw(0, 0, 1, 0, 0));
    wait_irq(t3);
    chk("R7 new reload in effect", t3 - t2, 10);
    wr(1'b1, cw(0, 1, 0, 0, 0));

    // R9 random intervals and divide selections (7 clamps to 64)
    for (int it = 0; it < 16; it++) begin
      int n = 1 + int'($urandom_range(29));
      int s = int'($urandom_range(7));
      if (it == 0) s = 7;
      wr(1'b0, 16'(n));
      wr(1'b1, cw(0, 0, 0, 0, s));
      wr(1'b1, cw(1, 0, 0, 0, s));
      t0 = cyc;
      rd(1'b1, d);
      chk("R9 divide field", int'(d[6:4]), s);
      wait_irq(t1);
      chk("R9 first interval", t1 - t0, exp_period(n, s));
      wr(1'b1, cw(0, 0, 1, 0, s));
      wait_irq(t2);
      chk("R9 repeat interval", t2 - t1, exp_period(n, s));
      wr(1'b1, cw(0, 1, 0, 0, s));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule